// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath half of a 32-bit processor that spreads each instruction over several short clock steps. It has one memory that serves both instruction fetch and data access. It has one ALU that also increments the program counter and forms branch targets. Staging registers carry values from one step to the next: the instruction register, the two operand latches A and B, the ALU result latch and the memory data latch.

An external sequencer drives the per-step control lines. These cover the program counter update, address source, memory read and write, instruction latch, ALU operand choice, ALU operation, register write-back and immediate extension. The datapath returns the opcode and function fields of the latched instruction and a flag that is set when the live ALU result is zero. The sequencer uses these to choose its next step. The memory contents after reset come from a parameter image.

Top module: `mc_datapath`

## Requirements
- R1: Synchronous active-low reset clears the program counter, the instruction register, all staging registers and all 32 general registers. The memory is loaded from the `MEM_INIT` image, with word i at bits [32i+31:32i].
- R2: The memory word index is bits [log2(MEM_WORDS)+1:2] of the address. The address is the program counter when `addr_sel`=0 and the ALU result latch when `addr_sel`=1. Read data is zero while `mem_rd` is low.
- R3: The instruction register loads the memory read data at a clock edge only when `ir_wr` is high; otherwise it holds. `opcode` is its bits [31:26] and `funct` is its bits [5:0].
- R4: The first ALU operand is the program counter when `opa_sel`=0 and latch A when `opa_sel`=1.
- R5: The second ALU operand follows `opb_sel`: 0 gives latch B, 1 gives the constant 4, 2 gives the extended immediate (instruction bits [15:0]), and 3 gives the extended immediate shifted left by two.
- R6: The immediate is sign-extended when `sext`=1 and zero-extended when `sext`=0.
- R7: When `rf_wr` is high, the register file is written at the clock edge. The target is rt (bits [20:16]) when `dst_sel`=0 and rd (bits [15:11]) when `dst_sel`=1. The data is the ALU result latch when `wb_sel`=0 and the memory data latch when `wb_sel`=1.
- R8: Register 0 reads as zero whatever is written to it.
- R9: With `pc_src`=0 a program counter write takes the live ALU result. With `pc_src`=1 it takes the ALU result latch.
- R10: The program counter is written when `pc_wr` is high, or when `pc_wr_cond` is high and `zero` is set; otherwise it holds.
- R11: On every clock edge, with no enable, latch A takes the rs read data (bits [25:21]), latch B takes the rt read data, the ALU result latch takes the live ALU result, and the memory data latch takes the memory read data.
- R12: `alu_op` 000 adds, 001 subtracts (first minus second), 010 ORs, and 100 takes the operation from `funct`: 0x20 adds and 0x22 subtracts. `zero` is high exactly when the 32-bit ALU result is all zero.
- R13: When `mem_wr` is high, the memory word at the ALU result latch address takes latch B at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_wr | input | 1 | Unconditional program counter write |
| pc_wr_cond | input | 1 | Program counter write when the zero flag is set |
| addr_sel | input | 1 | Memory address source: 0 program counter, 1 ALU result latch |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable |
| ir_wr | input | 1 | Instruction register load enable |
| wb_sel | input | 1 | Write-back data: 0 ALU result latch, 1 memory data latch |
| pc_src | input | 1 | Program counter source: 0 live ALU result, 1 ALU result latch |
| alu_op | input | 3 | ALU operation class |
| opa_sel | input | 1 | First ALU operand: 0 program counter, 1 latch A |
| opb_sel | input | 2 | Second ALU operand select |
| rf_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Write target: 0 rt, 1 rd |
| sext | input | 1 | Immediate extension: 1 sign, 0 zero |
| opcode | output | 6 | Instruction register bits [31:26] |
| funct | output | 6 | Instruction register bits [5:0] |
| zero | output | 1 | Live ALU result is zero |

## Verification
The bench acts as the controller and steps a short program through the datapath. The program contains immediate OR, register add and subtract, a store followed by a load of the same word, a taken branch, a branch that is not taken, and a write to register 0. The immediates and register values are chosen so that add and OR give different sums, and zero and sign extension give different values. A taken branch and an untaken branch land on instructions with different opcodes. Register contents are read back through probe instructions by comparing against an immediate with the zero flag. A fetch addressed through the result latch, a fetch with reads disabled, and a read-back of the stored word as an instruction separate the two address sources, the read gate and the store path.

// File: rtl/mc_pkg.sv
// Package mc_pkg
// Shared constants and encodings for the multicycle datapath.
// Assumes a fixed 32-bit instruction format with 5-bit register fields.
package mc_pkg;
    localparam int XLEN = 32;
    localparam int RAW  = 5;
    localparam int IMMW = 16;

    typedef enum logic [2:0] {
        AOP_ADD  = 3'b000,
        AOP_SUB  = 3'b001,
        AOP_OR   = 3'b010,
        AOP_FUNC = 3'b100
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG  = 2'd0,
        OPB_FOUR = 2'd1,
        OPB_IMM  = 2'd2,
        OPB_IMM4 = 2'd3
    } opb_sel_e;

    typedef enum logic [1:0] {
        K_ADD,
        K_SUB,
        K_OR
    } alu_kind_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
endpackage

// File: rtl/mc_alu.sv
// Module mc_alu
// Combinational ALU with its own operation decode: class from alu_op,
// refined by the function field for register-register instructions.
// Assumes unknown classes and function codes fall back to add.
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   alu_op,
    input  logic [5:0]   funct,
    output logic [W-1:0] result,
    output logic         zero
);
    alu_kind_e kind;

    // Decode operation class and function field into one ALU operation.
    always_comb begin
        case (alu_op_e'(alu_op))
            AOP_SUB:  kind = K_SUB;
            AOP_OR:   kind = K_OR;
            AOP_FUNC: kind = (funct == FN_SUB) ? K_SUB : K_ADD;
            default:  kind = K_ADD;
        endcase
    end

    // Compute the result for the selected operation.
    always_comb begin
        case (kind)
            K_SUB:   result = op_a - op_b;
            K_OR:    result = op_a | op_b;
            default: result = op_a + op_b;
        endcase
    end

    assign zero = (result == '0);
endmodule

// File: rtl/mc_regfile.sv
// Module mc_regfile
// General register file with two combinational read ports and one
// synchronous write port. Entry 0 is never written and reads as zero.
// Assumes a synchronous active-low reset that clears every entry.
module mc_regfile #(
    parameter int W    = 32,
    parameter int AW   = 5,
    localparam int NREG = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [NREG];

    // Clear on reset, otherwise write any entry other than 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R7: a write to a non-zero entry lands with the data presented.
    p_regwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

    // R8: a read of entry 0 returns zero even just after a write to it.
    p_r0_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0 && ra1 == '0) |=> ((ra1 != '0) || (rd1 == '0)));
endmodule

// File: rtl/mc_memory.sv
// Module mc_memory
// Word-addressed unified memory for instructions and data. It has a gated
// combinational read and a synchronous write. Reset loads a parameter image.
// Assumes byte addresses. The low two bits and the bits above the index
// are ignored, so addresses wrap.
module mc_memory #(
    parameter int W     = 32,
    parameter int WORDS = 16,
    parameter logic [WORDS*W-1:0] INIT = '0,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addr,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    logic [W-1:0]  mem [WORDS];
    logic [IW-1:0] idx;
    logic          unused_addr_bits;

    assign idx              = addr[IW+1:2];
    assign unused_addr_bits = ^{addr[W-1:IW+2], addr[1:0]};

    // Load the image on reset, otherwise store on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= INIT[i*W +: W];
        end else if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = rd_en ? mem[idx] : '0;

    // R13: a store leaves the written word in the addressed slot.
    p_store_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/mc_datapath.sv
// Module mc_datapath
// Multicycle datapath: program counter, staging registers, operand
// multiplexers, register file, unified memory and ALU, all steered by
// externally supplied per-step control lines.
// Assumes a controller outside this block sequences the steps and that
// reset is synchronous and active low.
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 16,
    parameter logic [MEM_WORDS*XLEN-1:0] MEM_INIT = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pc_wr,
    input  logic       pc_wr_cond,
    input  logic       addr_sel,
    input  logic       mem_rd,
    input  logic       mem_wr,
    input  logic       ir_wr,
    input  logic       wb_sel,
    input  logic       pc_src,
    input  logic [2:0] alu_op,
    input  logic       opa_sel,
    input  logic [1:0] opb_sel,
    input  logic       rf_wr,
    input  logic       dst_sel,
    input  logic       sext,
    output logic [5:0] opcode,
    output logic [5:0] funct,
    output logic       zero
);
    localparam int EXTW = XLEN - IMMW;

    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
    logic [XLEN-1:0] mem_addr, mem_rdata;
    logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
    logic [XLEN-1:0] imm_ext, opa, opb, alu_res, pc_next;
    logic [RAW-1:0]  f_rs, f_rt, f_rd, rf_wa;
    logic [IMMW-1:0] f_imm;
    logic            pc_load;

    assign f_rs   = ir_q[25:21];
    assign f_rt   = ir_q[20:16];
    assign f_rd   = ir_q[15:11];
    assign f_imm  = ir_q[IMMW-1:0];
    assign opcode = ir_q[31:26];
    assign funct  = ir_q[5:0];

    assign mem_addr = addr_sel ? aluout_q : pc_q;

    mc_memory #(
        .W     (XLEN),
        .WORDS (MEM_WORDS),
        .INIT  (MEM_INIT)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (mem_addr),
        .rd_en (mem_rd),
        .wr_en (mem_wr),
        .wdata (b_q),
        .rdata (mem_rdata)
    );

    assign rf_wa = dst_sel ? f_rd : f_rt;
    assign rf_wd = wb_sel ? mdr_q : aluout_q;

    mc_regfile #(
        .W  (XLEN),
        .AW (RAW)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (rf_wr),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    // Extend the 16-bit immediate; the fill width is derived from XLEN.
    generate
        if (EXTW > 0) begin : g_ext
            assign imm_ext = {{EXTW{sext & f_imm[IMMW-1]}}, f_imm};
        end else begin : g_noext
            assign imm_ext = f_imm[XLEN-1:0];
        end
    endgenerate

    // Select the first ALU operand.
    assign opa = opa_sel ? a_q : pc_q;

    // Select the second ALU operand.
    always_comb begin
        case (opb_sel_e'(opb_sel))
            OPB_REG:  opb = b_q;
            OPB_FOUR: opb = XLEN'(4);
            OPB_IMM:  opb = imm_ext;
            default:  opb = imm_ext << 2;
        endcase
    end

    mc_alu #(
        .W (XLEN)
    ) u_alu (
        .op_a   (opa),
        .op_b   (opb),
        .alu_op (alu_op),
        .funct  (funct),
        .result (alu_res),
        .zero   (zero)
    );

    assign pc_load = pc_wr | (pc_wr_cond & zero);
    assign pc_next = pc_src ? aluout_q : alu_res;

    // Program counter: cleared on reset, written on a qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (pc_load) pc_q <= pc_next;
    end

    // Instruction register: loads only when its enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_wr) ir_q <= mem_rdata;
    end

    // Staging latches: free-running, reloaded on every clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            mdr_q    <= '0;
        end else begin
            a_q      <= rf_rd1;
            b_q      <= rf_rd2;
            aluout_q <= alu_res;
            mdr_q    <= mem_rdata;
        end
    end

    // R10: with no qualified strobe the program counter holds.
    p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q));

    // R9: a sequential update takes the live ALU result.
    p_pc_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && !pc_src) |=> (pc_q == $past(alu_res)));

    // R9: a taken conditional update takes the latched target.
    p_pc_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond && zero && pc_src) |=> (pc_q == $past(aluout_q)));

    // R3: the instruction register holds without its enable.
    p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable(ir_q));

    // R11: the result latch follows the ALU on every cycle.
    p_aluout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (aluout_q == $past(alu_res)));

    // R11: the data latch follows the memory read on every cycle.
    p_mdr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mdr_q == $past(mem_rdata)));
endmodule

// File: tb/mc_datapath_tb.sv
`timescale 1ns/1ps
module mc_datapath_tb;
    localparam logic [31:0] W0  = {6'h0D, 5'd0, 5'd1, 16'h1234};
    localparam logic [31:0] W1  = {6'h0D, 5'd0, 5'd2, 16'h9234};
    localparam logic [31:0] W2  = {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20};
    localparam logic [31:0] W3  = {6'h00, 5'd3, 5'd1, 5'd4, 5'd0, 6'h22};
    localparam logic [31:0] W4  = {6'h2B, 5'd0, 5'd3, 16'h003C};
    localparam logic [31:0] W5  = {6'h23, 5'd0, 5'd5, 16'h003C};
    localparam logic [31:0] W6  = {6'h04, 5'd5, 5'd3, 16'h0001};
    localparam logic [31:0] W7  = {6'h0D, 5'd0, 5'd6, 16'h00FF};
    localparam logic [31:0] W8  = {6'h04, 5'd1, 5'd2, 16'h0003};
    localparam logic [31:0] W9  = {6'h0D, 5'd0, 5'd0, 16'hFFFF};
    localparam logic [31:0] W10 = {6'h3F, 5'd1, 5'd0, 16'h1234};
    localparam logic [31:0] W11 = {6'h3F, 5'd3, 5'd0, 16'hA468};
    localparam logic [31:0] W12 = {6'h3F, 5'd4, 5'd0, 16'h9234};
    localparam logic [31:0] W13 = {6'h3F, 5'd5, 5'd0, 16'hA468};
    localparam logic [31:0] W14 = {6'h3F, 5'd6, 5'd0, 16'h0000};
    localparam logic [31:0] W15 = 32'h0;
    localparam logic [16*32-1:0] IMAGE =
        {W15, W14, W13, W12, W11, W10, W9, W8, W7, W6, W5, W4, W3, W2, W1, W0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel, pc_src;
    logic [2:0] alu_op;
    logic       opa_sel;
    logic [1:0] opb_sel;
    logic       rf_wr, dst_sel, sext;
    logic [5:0] opcode, funct;
    logic       zero;
    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mc_datapath #(.MEM_WORDS(16), .MEM_INIT(IMAGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .wb_sel(wb_sel), .pc_src(pc_src), .alu_op(alu_op), .opa_sel(opa_sel),
        .opb_sel(opb_sel), .rf_wr(rf_wr), .dst_sel(dst_sel), .sext(sext),
        .opcode(opcode), .funct(funct), .zero(zero)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; mem_rd = 0; mem_wr = 0;
        ir_wr = 0; wb_sel = 0; pc_src = 0; alu_op = 3'b000; opa_sel = 0;
        opb_sel = 2'd0; rf_wr = 0; dst_sel = 0; sext = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic zchk(input string req, input logic exp);
        #1;
        chk(req, {31'b0, zero}, {31'b0, exp});
        clr();
    endtask

    task automatic fetch();
        clr(); mem_rd = 1; ir_wr = 1; opb_sel = 2'd1; pc_wr = 1; tick();
    endtask

    task automatic decode();
        clr(); opb_sel = 2'd3; sext = 1; tick();
    endtask

    task automatic do_ori();
        clr(); opa_sel = 1; opb_sel = 2'd2; alu_op = 3'b010; tick();
        clr(); rf_wr = 1; tick();
    endtask

    task automatic do_rtype();
        clr(); opa_sel = 1; alu_op = 3'b100; tick();
        clr(); rf_wr = 1; dst_sel = 1; tick();
    endtask

    task automatic do_addr();
        clr(); opa_sel = 1; opb_sel = 2'd2; sext = 1; tick();
    endtask

    task automatic do_branch();
        clr(); opa_sel = 1; alu_op = 3'b001; pc_wr_cond = 1; pc_src = 1; tick();
    endtask

    task automatic probe(input string req, input logic se, input logic exp);
        fetch();
        clr(); tick();
        opa_sel = 1; opb_sel = 2'd2; sext = se; alu_op = 3'b001;
        zchk(req, exp);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        clr();
        tick(); tick();
        rst_n = 1;
        // R1: cleared instruction register and operands after reset
        chk("R1 opcode", {26'b0, opcode}, 32'h0);
        chk("R1 funct", {26'b0, funct}, 32'h0);
        zchk("R1 pc+b zero", 1'b1);
        opb_sel = 2'd1;
        zchk("R5 const4", 1'b0);

        // w0: ORI r1
        fetch();
        chk("R2 R3 fetch opcode", {26'b0, opcode}, 32'h0D);
        chk("R3 fetch funct", {26'b0, funct}, 32'h34);
        opb_sel = 2'd1; alu_op = 3'b001;
        zchk("R9 R12 pc is 4", 1'b1);
        decode();
        chk("R3 ir holds", {26'b0, opcode}, 32'h0D);
        do_ori();
        fetch(); decode(); do_ori();               // w1: ORI r2 (zero-extended)
        fetch();
        chk("R3 rtype funct add", {26'b0, funct}, 32'h20);
        decode(); do_rtype();                     // w2: ADD r3
        fetch();
        chk("R3 rtype funct sub", {26'b0, funct}, 32'h22);
        decode(); do_rtype();                     // w3: SUB r4
        fetch();
        chk("R3 store opcode", {26'b0, opcode}, 32'h2B);
        decode(); do_addr();
        clr(); addr_sel = 1; mem_wr = 1; tick();  // w4: SW r3
        clr(); ir_wr = 1; tick();
        chk("R2 read gated", {26'b0, opcode}, 32'h0);
        fetch();
        chk("R10 pc held", {26'b0, opcode}, 32'h23);
        decode(); do_addr();
        clr(); addr_sel = 1; mem_rd = 1; tick();
        clr(); rf_wr = 1; wb_sel = 1; tick();     // w5: LW r5
        fetch(); decode(); do_branch();           // w6: taken
        fetch();
        chk("R10 R5 taken opcode", {26'b0, opcode}, 32'h04);
        chk("R10 taken funct", {26'b0, funct}, 32'h03);
        decode(); do_branch();                    // w8: not taken
        fetch();
        chk("R10 untaken opcode", {26'b0, opcode}, 32'h0D);
        chk("R10 untaken funct", {26'b0, funct}, 32'h3F);
        decode(); do_ori();                       // w9: write to r0
        clr(); tick();
        opa_sel = 1;
        zchk("R8 r0 stays zero", 1'b1);

        probe("R7 R6 ori r1", 1'b0, 1'b1);        // w10
        probe("R12 R7 add rd r3", 1'b0, 1'b1);    // w11
        opa_sel = 1; opb_sel = 2'd2; sext = 1; alu_op = 3'b001;
        zchk("R6 sign ext differs", 1'b0);
        probe("R12 sub r4", 1'b0, 1'b1);          // w12
        probe("R13 R7 load r5", 1'b0, 1'b1);      // w13
        fetch(); clr(); tick();                   // w14
        opa_sel = 1; alu_op = 3'b001;
        zchk("R10 skipped r6", 1'b1);
        zchk("R4 opa pc", 1'b0);
        opa_sel = 1;
        zchk("R4 opa a", 1'b1);

        fetch();                                  // w15 holds stored word
        chk("R13 stored opcode", {26'b0, opcode}, 32'h0);
        chk("R13 stored funct", {26'b0, funct}, 32'h28);
        fetch();                                  // wraps to w0, pc=0x44
        chk("R2 wrap opcode", {26'b0, opcode}, 32'h0D);
        clr(); opb_sel = 2'd1; tick();            // result latch = 0x48
        clr(); addr_sel = 1; mem_rd = 1; ir_wr = 1; tick();
        chk("R2 R11 latch addr opcode", {26'b0, opcode}, 32'h0);
        chk("R2 R11 latch addr funct", {26'b0, funct}, 32'h20);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule